// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block drives one successive-approximation converter over a serial link. For each sample it produces the convert strobe, the active-low select and the serial clock, shifts the result in most significant bit first, and presents it as a 32-bit word with a one-cycle valid strobe. All timing windows (quiet time, minimum convert-high time and conversion time) are set as nanosecond parameters. They are rounded up to whole cycles of the system clock at elaboration.

Three sequences are supported. Dedicated mode uses a separate convert line. Tied mode uses the select line as the convert line. Streaming mode uses an internal periodic trigger: each trigger starts a new conversion, and the result of the previous conversion is shifted out while the new one runs. A turbo input selects the shorter conversion window. The defaults describe the faster speed grade at a 250 MHz clock: 420 ns normal, 320 ns turbo, and a 2 MHz trigger. The slower grade uses 500/400 ns and has a 2 MHz trigger ceiling instead of 2.5 MHz. The sample width can be 14, 16 or 18 bits. A parameter selects sign extension (fully differential parts) or zero extension (pseudo-differential parts).

Top module: `sar_seq`

## Requirements
- R1: Dedicated mode (`mode_i`=0). The convert line rises in the cycle after the request is accepted. Select stays high for at least the conversion window. The read then happens with the convert line still high, and the convert line falls only after the read has ended and select is high again.
- R2: Tied mode (`mode_i`=1). Select is driven low for at least 5 cycles (20 ns quiet). It is then held high for at least the conversion window, and the read follows with select low.
- R3: The conversion window is 105 cycles (420 ns) when `turbo_i` is 0 and 80 cycles (320 ns) when it is 1. `turbo_i` is sampled when a request is accepted.
- R4: While `stream_en_i` is 1, a trigger fires every 125 cycles (2 MHz). Each trigger produces select low for at least 5 cycles, then high for at least 3 cycles (10 ns), then a read with select low. The read returns the result of the conversion started by the previous trigger.
- R5: A read shifts exactly SAMPLE_BITS bits, most significant first. With the default CPOL=0, CPHA=0, the serial clock idles low and data is sampled on its rising edge. The serial clock never leaves its idle level while select is high.
- R6: In dedicated and tied modes with SAMPLE_BITS of 16 or fewer, the result is sign-extended (when SIGNED_RESULT=1) into bits 15:0 and bits 31:16 are zero. Wider samples fill all 32 bits.
- R7: Streaming results are always extended to the full 32 bits, whatever the sample width.
- R8: `valid_o` is high for exactly one cycle per completed read, and `busy_o` is low in that cycle.
- R9: A request that arrives while the block is busy, or while streaming is enabled, is ignored: the running sequence and its result are unchanged. `drop_o` pulses in the following cycle.
- R10: After reset the convert line is low, select is high, the serial clock is at its idle level, and `busy_o`, `valid_o` and `drop_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start one conversion and read |
| mode_i | input | 1 | 0: dedicated convert line, 1: convert tied to select |
| turbo_i | input | 1 | Selects the short conversion window |
| stream_en_i | input | 1 | Runs the periodic streaming trigger |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Dedicated convert strobe |
| cs_n_o | output | 1 | Active-low select (convert line in tied and streaming use) |
| sclk_o | output | 1 | Serial clock |
| busy_o | output | 1 | A sequence is in progress |
| drop_o | output | 1 | One-cycle flag for an ignored request or trigger |
| sample_o | output | 32 | Extended result |
| valid_o | output | 1 | One-cycle strobe for `sample_o` |

## Verification
Two things can share a cycle in this block. The first is a new request that lands while a conversion window is still running. The bench pulses `req_i` in the middle of a dedicated conversion. It judges the case correct when `drop_o` rises in the next cycle and the sample that later appears still matches the value the converter model produced for the original request. The second is streaming, where the read of one result overlaps the conversion of the next. The converter model in the bench keeps both the latest and the previous result, and every streamed sample must equal the earlier one.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DC_CONV,
        S_TQ_QUIET,
        S_TQ_CONV,
        S_ST_QUIET,
        S_ST_HIGH,
        S_READ
    } seq_st_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns_to_cyc(input longint ns, input longint hz);
        return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    // clock cycles per trigger period, rounded up
    function automatic int hz_to_cyc(input longint clk_hz, input longint rate_hz);
        return int'((clk_hz + rate_hz - 1) / rate_hz);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sar_tick.sv
module sar_tick #(
    parameter int PERIOD = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = $clog2(PERIOD) + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          tick;
    } tick_s;

    tick_s q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (!en_i) begin
            d.cnt = '0;
        end else if (q.cnt == PW'(PERIOD - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

    // R4: a trigger only follows a cycle with streaming enabled
    assert_tick_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en_i));

endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
    parameter int N    = 14,
    parameter int HALF = 2,
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic         sdo_i,
    output logic         sclk_o,
    output logic         done_o,
    output logic [N-1:0] data_o
);
    localparam logic LEAD = CPOL ^ CPHA;
    localparam int   HCW  = $clog2(HALF) + 1;
    localparam int   BCW  = $clog2(N) + 1;

    typedef struct packed {
        logic           act;
        logic           ph;
        logic [HCW-1:0] hc;
        logic [BCW-1:0] bc;
        logic           sclk;
        logic           done;
        logic [N-1:0]   sh;
    } rx_s;

    rx_s q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go_i) begin
            d.act  = 1'b1;
            d.ph   = 1'b0;
            d.hc   = '0;
            d.bc   = '0;
            d.sclk = LEAD;
        end else if (q.act) begin
            if (q.hc == HCW'(HALF - 1)) begin
                d.hc = '0;
                if (!q.ph) begin
                    d.ph   = 1'b1;
                    d.sclk = ~LEAD;
                    d.sh   = {q.sh[N-2:0], sdo_i};
                end else if (q.bc == BCW'(N - 1)) begin
                    d.act  = 1'b0;
                    d.done = 1'b1;
                    d.sclk = CPOL;
                end else begin
                    d.bc   = q.bc + 1'b1;
                    d.ph   = 1'b0;
                    d.sclk = LEAD;
                end
            end else begin
                d.hc = q.hc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= CPOL;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign done_o = q.done;
    assign data_o = q.sh;

    // R5: completion only ends an active shift
    assert_done_ends_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(q.act));

endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
    parameter int N      = 14,
    parameter bit SIGNED = 1'b1
) (
    input  logic [N-1:0] raw_i,
    input  logic         wide_i,
    output logic [31:0]  word_o
);
    logic        top_bit;
    logic [31:0] full;

    always_comb begin
        top_bit = SIGNED ? raw_i[N-1] : 1'b0;
        full    = {{(32-N){top_bit}}, raw_i};
        if (wide_i || (N > 16)) word_o = full;
        else                    word_o = {16'h0000, full[15:0]};
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int CLK_HZ        = 250_000_000,
    parameter int SAMPLE_BITS   = 14,
    parameter bit SIGNED_RESULT = 1'b1,
    parameter int CONV_NS       = 420,
    parameter int CONV_TURBO_NS = 320,
    parameter int QUIET_NS      = 20,
    parameter int CNV_HIGH_NS   = 10,
    parameter int TRIG_HZ       = 2_000_000,
    parameter int SCLK_HALF     = 2,
    parameter bit CPOL          = 1'b0,
    parameter bit CPHA          = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        mode_i,
    input  logic        turbo_i,
    input  logic        stream_en_i,
    input  logic        sdo_i,
    output logic        cnv_o,
    output logic        cs_n_o,
    output logic        sclk_o,
    output logic        busy_o,
    output logic        drop_o,
    output logic [31:0] sample_o,
    output logic        valid_o
);
    import sar_seq_pkg::*;

    localparam int CN_CYC = ns_to_cyc(CONV_NS, CLK_HZ);
    localparam int CT_CYC = ns_to_cyc(CONV_TURBO_NS, CLK_HZ);
    localparam int Q_CYC  = ns_to_cyc(QUIET_NS, CLK_HZ);
    localparam int H_CYC  = ns_to_cyc(CNV_HIGH_NS, CLK_HZ);
    localparam int T_CYC  = hz_to_cyc(CLK_HZ, TRIG_HZ);
    localparam int MAXC   = max4(CN_CYC, CT_CYC, Q_CYC, H_CYC);
    localparam int CW     = $clog2(MAXC + 1) + 1;

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          cnv;
        logic          cs_n;
        logic          strm;
        logic          rx_go;
        logic          drop;
        logic          vld;
        logic [31:0]   smp;
    } seq_s;

    seq_s q, d;

    logic                   tick;
    logic                   rx_done;
    logic [SAMPLE_BITS-1:0] rx_data;
    logic [31:0]            fmt_word;

    sar_tick #(.PERIOD(T_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (stream_en_i),
        .tick_o (tick)
    );

    sar_rx #(.N(SAMPLE_BITS), .HALF(SCLK_HALF), .CPOL(CPOL), .CPHA(CPHA)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (q.rx_go),
        .sdo_i  (sdo_i),
        .sclk_o (sclk_o),
        .done_o (rx_done),
        .data_o (rx_data)
    );

    sar_fmt #(.N(SAMPLE_BITS), .SIGNED(SIGNED_RESULT)) u_fmt (
        .raw_i  (rx_data),
        .wide_i (q.strm),
        .word_o (fmt_word)
    );

    always_comb begin
        d       = q;
        d.rx_go = 1'b0;
        d.drop  = 1'b0;
        d.vld   = 1'b0;
        d.cnt   = q.cnt + 1'b1;
        unique case (q.st)
            S_IDLE: begin
                d.cnt  = '0;
                d.cnv  = 1'b0;
                d.cs_n = 1'b1;
                if (tick) begin
                    d.st   = S_ST_QUIET;
                    d.strm = 1'b1;
                    d.cs_n = 1'b0;
                end else if (req_i && !stream_en_i) begin
                    d.strm = 1'b0;
                    d.lim  = turbo_i ? CW'(CT_CYC) : CW'(CN_CYC);
                    if (mode_i) begin
                        d.st   = S_TQ_QUIET;
                        d.cs_n = 1'b0;
                    end else begin
                        d.st  = S_DC_CONV;
                        d.cnv = 1'b1;
                    end
                end
                if (req_i && stream_en_i) d.drop = 1'b1;
            end
            S_DC_CONV: begin
                if (q.cnt == q.lim - 1'b1) begin
                    d.st    = S_READ;
                    d.cs_n  = 1'b0;
                    d.rx_go = 1'b1;
                end
            end
            S_TQ_QUIET: begin
                if (q.cnt == CW'(Q_CYC - 1)) begin
                    d.st   = S_TQ_CONV;
                    d.cs_n = 1'b1;
                    d.cnt  = '0;
                end
            end
            S_TQ_CONV: begin
                if (q.cnt == q.lim - 1'b1) begin
                    d.st    = S_READ;
                    d.cs_n  = 1'b0;
                    d.rx_go = 1'b1;
                end
            end
            S_ST_QUIET: begin
                if (q.cnt == CW'(Q_CYC - 1)) begin
                    d.st   = S_ST_HIGH;
                    d.cs_n = 1'b1;
                    d.cnt  = '0;
                end
            end
            S_ST_HIGH: begin
                if (q.cnt == CW'(H_CYC - 1)) begin
                    d.st    = S_READ;
                    d.cs_n  = 1'b0;
                    d.rx_go = 1'b1;
                end
            end
            S_READ: begin
                if (rx_done) begin
                    d.st   = S_IDLE;
                    d.cs_n = 1'b1;
                    d.cnv  = 1'b0;
                    d.vld  = 1'b1;
                    d.smp  = fmt_word;
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (q.st != S_IDLE && (req_i || tick)) d.drop = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cnv_o    = q.cnv;
    assign cs_n_o   = q.cs_n;
    assign busy_o   = (q.st != S_IDLE);
    assign drop_o   = q.drop;
    assign valid_o  = q.vld;
    assign sample_o = q.smp;

    // R1: in dedicated use the convert line spans the whole read
    assert_cnv_spans_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cs_n_o && (q.st == S_READ) && !q.strm && $past(cnv_o)) |-> cnv_o);

    // R2: the dedicated convert line is never used by the tied sequences
    assert_tied_no_cnv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_TQ_QUIET || q.st == S_TQ_CONV || q.st == S_ST_QUIET || q.st == S_ST_HIGH) |-> !cnv_o);

    // R5: no serial clock activity while deselected
    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (sclk_o == CPOL));

    // R6: narrow single results leave the upper half clear
    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !q.strm && (SAMPLE_BITS <= 16)) |-> (sample_o[31:16] == 16'h0000));

    // R7: streamed results carry the extension into bit 31
    assert_stream_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && q.strm && SIGNED_RESULT) |-> (sample_o[31] == sample_o[SAMPLE_BITS-1]));

    // R8: valid is a single-cycle strobe outside a busy sequence
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

    // R9: a request while busy is flagged in the next cycle
    assert_drop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && busy_o) |=> drop_o);

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
    localparam int NB   = 14;
    localparam int QC   = 5;
    localparam int HC   = 3;
    localparam int CNC  = 105;
    localparam int CTC  = 80;
    localparam int TRG  = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        turbo_i = 1'b0;
    logic        stream_en_i = 1'b0;
    logic        sdo_i = 1'b0;
    logic        cnv_o, cs_n_o, sclk_o, busy_o, drop_o, valid_o;
    logic [31:0] sample_o;

    always #2 clk = ~clk;

    sar_seq u_dut (
        .clk (clk), .rst_n (rst_n), .req_i (req_i), .mode_i (mode_i),
        .turbo_i (turbo_i), .stream_en_i (stream_en_i), .sdo_i (sdo_i),
        .cnv_o (cnv_o), .cs_n_o (cs_n_o), .sclk_o (sclk_o), .busy_o (busy_o),
        .drop_o (drop_o), .sample_o (sample_o), .valid_o (valid_o)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int bmode = 0;
    int conv_exp = CNC;
    int last_st = -1;
    int stream_vld = 0;
    int kval = 0;

    int cur_v = 0, prev_v = 0, ld_v = 0;
    logic [NB-1:0] shreg = '0;
    int t_cnv = 0, t_lo = 0, t_hi = 0, bits = 0;
    bit sclk_seen = 0, hi_armed = 0;
    bit p_cs = 1, p_cnv = 0, p_sclk = 0, p_vld = 0;
    logic [31:0] expq[$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int next_val();
        int v;
        case (kval)
            0: v = 'h2000;
            1: v = 'h1FFF;
            2: v = 0;
            3: v = 'h3FFF;
            default: v = int'($urandom) & 'h3FFF;
        endcase
        kval++;
        return v;
    endfunction

    function automatic logic [31:0] expect_word(input int raw, input bit wide);
        int s;
        s = raw;
        if (raw >= (1 << (NB - 1))) s = raw - (1 << NB);
        if (wide || NB > 16) return 32'(s);
        return {16'h0000, 16'(s)};
    endfunction

    task automatic conv_start();
        prev_v = cur_v;
        cur_v  = next_val();
    endtask

    // converter model and per-clock comparison
    always @(negedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
        if (rst_n) begin
            check(!(cs_n_o && sclk_o !== 1'b0), "R5 sclk idle while deselected", sclk_o, 0);
            if (cnv_o && !p_cnv) begin
                conv_start();
                t_cnv = cyc;
            end
            if (!cnv_o && p_cnv)
                check(cs_n_o && sclk_seen && bits == NB, "R1 convert falls after read", bits, NB);
            if (!cs_n_o && p_cs) begin
                if (bmode == 0)
                    check(cnv_o && (cyc - t_cnv) >= conv_exp, "R1/R3 dedicated window", cyc - t_cnv, conv_exp);
                else if (hi_armed && bmode == 1)
                    check((cyc - t_hi) >= conv_exp, "R2/R3 tied high window", cyc - t_hi, conv_exp);
                else if (hi_armed)
                    check((cyc - t_hi) >= HC, "R4 stream high time", cyc - t_hi, HC);
                hi_armed  = 0;
                t_lo      = cyc;
                sclk_seen = 0;
                bits      = 0;
                ld_v      = (bmode == 2) ? prev_v : cur_v;
                shreg     = NB'(ld_v);
                sdo_i     = shreg[NB-1];
            end
            if (cs_n_o && !p_cs) begin
                if (sclk_seen) begin
                    check(bits == NB, "R5 bit count", bits, NB);
                    expq.push_back(expect_word(ld_v, bmode == 2));
                end else if (bmode != 0) begin
                    check((cyc - t_lo) >= QC, "R2/R4 quiet time", cyc - t_lo, QC);
                    conv_start();
                    t_hi     = cyc;
                    hi_armed = 1;
                    if (bmode == 2 && last_st >= 0)
                        check((cyc - last_st) == TRG, "R4 trigger period", cyc - last_st, TRG);
                    if (bmode == 2) last_st = cyc;
                end
            end
            if (sclk_o && !p_sclk) begin
                sclk_seen = 1;
                bits++;
            end
            if (!sclk_o && p_sclk && !cs_n_o) begin
                shreg = {shreg[NB-2:0], 1'b0};
                sdo_i = shreg[NB-1];
            end
            if (valid_o) begin
                if (expq.size() == 0) begin
                    check(0, "R8 unexpected valid", sample_o, 0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    check(sample_o == e, (bmode == 2) ? "R4/R7 streamed sample" : "R6 sample",
                          sample_o, e);
                end
                check(!busy_o && !p_vld, "R8 valid strobe", busy_o, 0);
                if (bmode == 2) stream_vld++;
            end
        end
        p_cs   = cs_n_o;
        p_cnv  = cnv_o;
        p_sclk = sclk_o;
        p_vld  = valid_o;
    end

    task automatic one_req(input bit md, input bit tb);
        @(negedge clk);
        bmode    = md;
        conv_exp = tb ? CTC : CNC;
        mode_i   = md;
        turbo_i  = tb;
        req_i    = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cnv_o && cs_n_o && !sclk_o && !busy_o && !valid_o && !drop_o,
              "R10 reset state", {cnv_o, cs_n_o, sclk_o, busy_o, valid_o, drop_o}, 6'b010000);

        one_req(0, 0);
        one_req(0, 1);
        one_req(1, 0);
        one_req(1, 1);

        // R9: request during a dedicated conversion
        @(negedge clk);
        bmode = 0; conv_exp = CNC; mode_i = 0; turbo_i = 0; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (10) @(negedge clk);
        mode_i = 1; turbo_i = 1; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check(drop_o == 1'b1, "R9 drop flag", drop_o, 1);
        @(negedge clk);
        check(drop_o == 1'b0 && busy_o && cnv_o, "R9 sequence unchanged", drop_o, 0);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);

        // streaming: previous result read during the next conversion
        last_st = -1;
        bmode   = 2;
        stream_en_i = 1'b1;
        while (stream_vld < 6) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check(drop_o == 1'b1, "R9 request during streaming", drop_o, 1);
        stream_en_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);

        one_req(1, 0);
        one_req(0, 0);
        check(expq.size() == 0, "R8 every read delivered", expq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule